// File: doc/BRIEF.md
# Rank-Pair Tie Group Scanner

This block takes a stream of packed rank pairs, one word per cycle, and builds the tie-corrected numerator of a rank correlation. Each word carries a u rank in its upper half and a v rank in its lower half. The caller makes two passes over the same n pairs. The first pass presents the pairs sorted by u and then by v. During that pass the block sums a tie term over every run of equal u values and over every run of equal (u, v) pairs. The second pass presents the pairs sorted by v alone, and the block sums the same term over runs of equal v values.

When the closing beat of the second pass arrives, the block folds the three sums together with the total pair count n(n-1)/2 and an externally supplied discordant count. The result is one signed integer, marked by a single-cycle done strobe. After the strobe the sums clear, so the next computation can start on the following beat. Sorting, the division and the square root all sit outside the block.

Top module: `rank_tie_scan`

## Requirements
- R1: While reset is applied, and after it is released, `done_o` is low and `num_o` reads 0 until the first computation completes.
- R2: The u rank is taken from word bits [30:16] and the v rank from bits [14:0]. Bits 31 and 15 have no effect on any result.
- R3: A run of w equal keys adds w(w-1)/2 to its sum. A run of length 1 adds nothing.
- R4: With `mode_i` = 0, runs of equal u add to the u-tie sum and runs of equal (u, v) pairs add to the joint-tie sum.
- R5: With `mode_i` = 1, runs of equal v add to the v-tie sum. The u field is ignored, and the u-tie and joint-tie sums are left unchanged.
- R6: A run closes when its key changes or on a beat with `last_i` high. The beat after a `last_i` beat always starts a new run, even when it carries the same key.
- R7: Cycles with `valid_i` low are ignored, whatever `last_i`, `mode_i` and the word hold. They neither break a run nor end a pass.
- R8: The result is n(n-1)/2 minus the u-tie sum, minus the v-tie sum, plus the joint-tie sum, minus twice `nd_i`. It is given as a 33-bit two's-complement value. `n_i` and `nd_i` are taken on the closing beat.
- R9: `done_o` is high for exactly one cycle: the cycle after the beat that has `valid_i`, `last_i` and `mode_i` all high. `num_o` holds its value until the next strobe.
- R10: The closing beat clears all three tie sums, so back-to-back computations are independent.
- R11: When no value repeats in either rank, the result equals n(n-1)/2 minus twice `nd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | A rank-pair word is present this cycle |
| last_i | input | 1 | This word ends the current pass |
| word_i | input | 32 | Packed pair: u in [30:16], v in [14:0] |
| mode_i | input | 1 | 0: u-then-v sorted pass; 1: v sorted pass |
| n_i | input | 15 | Element count n |
| nd_i | input | 32 | Discordant pair count |
| done_o | output | 1 | One-cycle strobe: result valid |
| num_o | output | 33 | Signed tie-adjusted numerator |

## Verification
A beat is registered on the clock edge that samples it. The result and the strobe therefore appear in the cycle right after the closing beat of the second pass, and the strobe drops one cycle later while the value stays. The bench drives each beat on a falling edge and reads the outputs on the next falling edge. This puts its sample half a period after the edge that updates them. It also checks at every driven beat that no strobe came early.

// File: rtl/rank_tie_pkg.sv
package rank_tie_pkg;
  localparam int RANK_W = 15;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int CNT_W  = RANK_W + 1;
  localparam int SUM_W  = 2 * CNT_W;
  localparam int NUM_W  = SUM_W + 1;

  typedef logic [SUM_W-1:0] sum_t;

  // w*(w-1)/2 for a run of w equal keys
  function automatic sum_t pair_count(input logic [CNT_W-1:0] w);
    logic [2*CNT_W-1:0] prod;
    prod = (2*CNT_W)'(w) * ((2*CNT_W)'(w) - 1'b1);
    return sum_t'(prod >> 1);
  endfunction
endpackage

// File: rtl/rank_tie_run.sv
module rank_tie_run
  import rank_tie_pkg::*;
#(
  parameter int KEY_W = RANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             last_i,
  input  logic [KEY_W-1:0] key_i,
  output sum_t             inc_o
);
  logic [KEY_W-1:0] prev_q, prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_cur;
  logic             fresh_q, fresh_d;
  logic             match;

  always_comb begin
    match   = !fresh_q && (key_i == prev_q);
    cnt_cur = match ? cnt_q + 1'b1 : CNT_W'(1);
    inc_o   = '0;
    if (beat_i && !fresh_q && !match) inc_o = pair_count(cnt_q);
    if (beat_i && last_i)             inc_o = inc_o + pair_count(cnt_cur);
    prev_d  = prev_q;
    cnt_d   = cnt_q;
    fresh_d = fresh_q;
    if (beat_i) begin
      prev_d  = key_i;
      cnt_d   = cnt_cur;
      fresh_d = last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else if (beat_i) begin
      prev_q  <= prev_d;
      cnt_q   <= cnt_d;
      fresh_q <= fresh_d;
    end
  end

  // R6: a closing beat always leaves the tracker ready for a new run
  a_r6_fresh_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    beat_i && last_i |=> fresh_q);
  // R3: an open run never has length zero
  a_r3_open_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh_q |-> cnt_q != '0);
  // R7: idle cycles leave run state untouched
  a_r7_idle_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_i |=> $stable(cnt_q) && $stable(fresh_q) && $stable(prev_q));
endmodule

// File: rtl/rank_tie_fold.sv
module rank_tie_fold
  import rank_tie_pkg::*;
(
  input  logic [RANK_W-1:0] n_i,
  input  sum_t              n1_i,
  input  sum_t              n2_i,
  input  sum_t              n3_i,
  input  sum_t              nd_i,
  output logic [NUM_W-1:0]  num_o
);
  logic [2*RANK_W-1:0] nn;
  logic [NUM_W-1:0]    n0_e, n1_e, n2_e, n3_e, nd_e;

  always_comb begin
    nn    = (2*RANK_W)'(n_i) * ((2*RANK_W)'(n_i) - 1'b1);
    n0_e  = NUM_W'(nn >> 1);
    n1_e  = NUM_W'(n1_i);
    n2_e  = NUM_W'(n2_i);
    n3_e  = NUM_W'(n3_i);
    nd_e  = NUM_W'(nd_i);
    // modular arithmetic is exact because the true result fits NUM_W signed
    num_o = n0_e - n1_e - n2_e + n3_e - (nd_e << 1);
  end
endmodule

// File: rtl/rank_tie_scan.sv
module rank_tie_scan
  import rank_tie_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              mode_i,
  input  logic [RANK_W-1:0] n_i,
  input  logic [SUM_W-1:0]  nd_i,
  output logic              done_o,
  output logic [NUM_W-1:0]  num_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic [RANK_W-1:0] u_key, v_key, single_key;
  logic              beat_j, closing;
  sum_t              inc_s, inc_j;
  sum_t              n1_q, n1_d, n2_q, n2_d, n3_q, n3_d, n2_final;
  logic [NUM_W-1:0]  num_q, num_d, num_fold;
  logic              done_q;
  logic              unused_pad;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign u_key      = word_i[HALF_W +: RANK_W];
  assign v_key      = word_i[0 +: RANK_W];
  assign unused_pad = word_i[WORD_W-1] ^ word_i[HALF_W-1];
  assign single_key = mode_i ? v_key : u_key;
  assign beat_j     = valid_i && !mode_i;
  assign closing    = valid_i && last_i && mode_i;

  rank_tie_run #(.KEY_W(RANK_W)) single_run_i (
    .clk    (clk),
    .rst_n  (rst_sn),
    .beat_i (valid_i),
    .last_i (last_i),
    .key_i  (single_key),
    .inc_o  (inc_s)
  );

  rank_tie_run #(.KEY_W(2*RANK_W)) joint_run_i (
    .clk    (clk),
    .rst_n  (rst_sn),
    .beat_i (beat_j),
    .last_i (last_i),
    .key_i  ({u_key, v_key}),
    .inc_o  (inc_j)
  );

  assign n2_final = n2_q + inc_s;

  rank_tie_fold fold_i (
    .n_i   (n_i),
    .n1_i  (n1_q),
    .n2_i  (n2_final),
    .n3_i  (n3_q),
    .nd_i  (nd_i),
    .num_o (num_fold)
  );

  always_comb begin
    n1_d  = n1_q;
    n2_d  = n2_q;
    n3_d  = n3_q;
    num_d = num_q;
    if (closing) begin
      n1_d  = '0;
      n2_d  = '0;
      n3_d  = '0;
      num_d = num_fold;
    end else if (beat_j) begin
      n1_d = n1_q + inc_s;
      n3_d = n3_q + inc_j;
    end else if (valid_i) begin
      n2_d = n2_final;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      n1_q   <= '0;
      n2_q   <= '0;
      n3_q   <= '0;
      num_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= closing;
      if (valid_i) begin
        n1_q  <= n1_d;
        n2_q  <= n2_d;
        n3_q  <= n3_d;
        num_q <= num_d;
      end
    end
  end

  assign done_o = done_q;
  assign num_o  = num_q;

  // R10: the strobe cycle always sees cleared sums
  a_r10_clear_on_done: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> (n1_q == '0) && (n2_q == '0) && (n3_q == '0));
  // R7: idle cycles change no sum and raise no strobe
  a_r7_idle_no_effect: assert property (@(posedge clk) disable iff (!rst_sn)
    !valid_i |=> $stable(n1_q) && $stable(n2_q) && $stable(n3_q) && !done_q);
  // R9: result changes only together with the strobe
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_sn)
    !done_q |-> $stable(num_q));
  // R5: a v pass never touches the u and joint sums except by the clear
  a_r5_v_pass_isolated: assert property (@(posedge clk) disable iff (!rst_sn)
    valid_i && mode_i && !last_i |=> $stable(n1_q) && $stable(n3_q));
endmodule

// File: tb/rank_tie_scan_tb_top.sv
`timescale 1ns/1ps
module rank_tie_scan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, last, mode;
  logic [31:0] word;
  logic [14:0] n_val;
  logic [31:0] nd_val;
  logic        done;
  logic [32:0] num;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit early = 0;
  bit big = 0;
  int big_n = 0;
  int ua[48];
  int va[48];
  int ia[48];

  always #2.5 clk = ~clk;

  rank_tie_scan dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .last_i(last), .word_i(word),
    .mode_i(mode), .n_i(n_val), .nd_i(nd_val), .done_o(done), .num_o(num)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int u, input int v);
    logic [31:0] w;
    w = $urandom;
    w[30:16] = u[14:0];
    w[14:0]  = v[14:0];
    return w;
  endfunction

  function automatic logic [31:0] word_at(input int k, input bit m);
    if (big) return m ? pack(big_n - 1 - k, k) : pack(k, big_n - 1 - k);
    return pack(ua[ia[k]], va[ia[k]]);
  endfunction

  function automatic longint key_of(input int i, input bit by_v);
    return by_v ? longint'(va[i]) : longint'(ua[i]) * 65536 + va[i];
  endfunction

  task automatic sort_idx(input int n, input bit by_v);
    for (int i = 0; i < n; i++) ia[i] = i;
    for (int i = 0; i < n; i++)
      for (int j = 0; j + 1 < n - i; j++)
        if (key_of(ia[j], by_v) > key_of(ia[j+1], by_v)) begin
          int t = ia[j];
          ia[j] = ia[j+1];
          ia[j+1] = t;
        end
  endtask

  task automatic push(input int n, input bit m, input bit gaps);
    for (int k = 0; k < n; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        if (done) early = 1;
        valid = 1'b0; last = $urandom; word = $urandom; mode = $urandom;
      end
      @(negedge clk);
      if (done) early = 1;
      valid = 1'b1; last = (k == n - 1); word = word_at(k, m); mode = m;
    end
  endtask

  task automatic finish_case(input longint exp, input string tag);
    longint act;
    @(negedge clk);
    act = longint'($signed(num));
    check(done === 1'b1, {tag, " R9 strobe after closing beat"}, longint'(done), 1);
    check(act == exp, {tag, " R8 numerator"}, act, exp);
    valid = 1'b0; last = 1'b0;
    @(negedge clk);
    check(done === 1'b0, {tag, " R9 strobe lasts one cycle"}, longint'(done), 0);
    check(longint'($signed(num)) == exp, {tag, " R9 result held"}, longint'($signed(num)), exp);
    check(!early, {tag, " R9 no early strobe"}, longint'(early), 0);
    early = 0;
  endtask

  task automatic run_case(input int n, input longint nd, input bit gaps, input string tag);
    longint n0, n1, n2, n3;
    n0 = longint'(n) * (n - 1) / 2;
    n1 = 0; n2 = 0; n3 = 0;
    for (int i = 0; i < n; i++)
      for (int j = i + 1; j < n; j++) begin
        if (ua[i] == ua[j]) n1++;
        if (va[i] == va[j]) n2++;
        if (ua[i] == ua[j] && va[i] == va[j]) n3++;
      end
    n_val = n[14:0];
    nd_val = nd[31:0];
    sort_idx(n, 1'b0);
    push(n, 1'b0, gaps);
    sort_idx(n, 1'b1);
    push(n, 1'b1, gaps);
    finish_case(n0 - n1 - n2 + n3 - 2 * nd, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint bn0;
    void'($urandom(32'd7719));
    valid = 0; last = 0; mode = 0; word = '0; n_val = '0; nd_val = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(done === 1'b0, "R1 strobe low in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1 strobe low after reset", longint'(done), 0);
    check(num === '0, "R1 result zero after reset", longint'($signed(num)), 0);

    // R11: all distinct ranks
    for (int i = 0; i < 8; i++) begin ua[i] = i; va[i] = (i * 3 + 1) % 8; end
    run_case(8, 5, 1'b0, "R11 distinct");
    // R3: single element, run of one
    ua[0] = 4; va[0] = 4;
    run_case(1, 0, 1'b0, "R3 single element");
    // R3 R4: one long u run, v distinct
    for (int i = 0; i < 20; i++) begin ua[i] = 7; va[i] = i; end
    run_case(20, 3, 1'b0, "R3 R4 long u run");
    // R6: last u key of pass A equals first v key of pass B
    ua[0] = 0; va[0] = 9; ua[1] = 9; va[1] = 9;
    run_case(2, 0, 1'b0, "R6 restart after last");
    // R7: idle gaps with junk inside runs
    for (int i = 0; i < 30; i++) begin ua[i] = $urandom % 4; va[i] = $urandom % 4; end
    run_case(30, 11, 1'b1, "R7 idle gaps");
    // R8: largest n, fully discordant, negative result
    big = 1; big_n = 32767;
    bn0 = longint'(big_n) * (big_n - 1) / 2;
    n_val = 15'(big_n); nd_val = bn0[31:0];
    push(big_n, 1'b0, 1'b0);
    push(big_n, 1'b1, 1'b0);
    finish_case(-bn0, "R8 extreme n");
    big = 0;
    // random back-to-back computations
    for (int c = 0; c < 10; c++) begin
      int n, rng;
      longint n0;
      n = 2 + $urandom % 40;
      rng = (c % 3 == 0) ? 2 : ((c % 3 == 1) ? 5 : 40);
      for (int i = 0; i < n; i++) begin ua[i] = $urandom % rng; va[i] = $urandom % rng; end
      n0 = longint'(n) * (n - 1) / 2;
      run_case(n, longint'($urandom % (n0 + 1)), c[0], "R2 R4 R5 R10 random");
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule